// File: doc/BRIEF.md
# Eight-Operand Pipelined Carry-Save Summer

This block adds eight small unsigned operands per clock and delivers their exact total five cycles later. A new set of operands may be presented on every cycle, so the block sustains one result per clock with no stalls. It is intended as a reduction tail in a datapath where many narrow terms must be combined at full clock rate.

Internally the operands are not all reduced in the same cycle. The first four lanes enter a carry-save [4:2] compressor right away. The remaining lanes are held in skew registers, and then join the running carry-save pair two at a time in the next two stages. A Kogge-Stone style parallel-prefix adder turns the final pair into a binary sum. Its prefix levels are split across two pipeline stages, so every stage has a logic depth close to that of one compressor.

With the default operand width of 6 bits, the largest total is 8 x 63 = 504, so the result is 9 bits wide. The result bus is as wide as the operand width plus three.

Top module: `sum8_pipe`

## Requirements
- R1: When `out_valid` is high, `sum_out` equals the sum of the eight lanes of `ops_in` that were presented with `in_valid` high exactly five rising edges earlier. Lane k occupies bits [k*OPW +: OPW].
- R2: `out_valid` is high in the cycle that follows the fifth rising edge after a cycle in which `in_valid` was high.
- R3: Sets presented on consecutive cycles are each summed correctly, with no interaction between neighbouring sets.
- R4: With every lane at its maximum value (63 at the default width), the result is 504 and does not wrap. The result never exceeds eight times the lane maximum.
- R5: While `rst_n` is low at a rising edge, and on the cycle after it, `out_valid` is low. Any set still inside the pipeline when reset is applied never produces a valid output.
- R6: A cycle with `in_valid` low produces a cycle with `out_valid` low five edges later, and the lane values in that cycle have no effect on the results of the valid sets around it.
- R7: A set in which all lanes are zero produces a result of 0.
- R8: Each lane adds with unit weight, whichever stage it joins in. A set with one lane at 63 and all other lanes at 0 produces 63 for each of the eight lane positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks `ops_in` as a set to be summed this cycle |
| ops_in | input | 8*OPW | Eight unsigned lanes; lane k at bits [k*OPW +: OPW] |
| sum_out | output | OPW+3 | Total of the set that entered five cycles earlier |
| out_valid | output | 1 | Marks `sum_out` as holding a valid total |

## Verification
The bench builds the block with its default operand width of 6. At that width the all-63 set reaches the 9-bit ceiling of 504 exactly, so any dropped carry at the top of the compressors or of the prefix adder becomes visible. Walking a single 63 across every lane drives each skew path on its own, separately from the first-stage lanes. Back-to-back random sets, a stream with alternating idle cycles, and a reset applied while sets are still in flight show that the valid pipeline and the data pipeline stay in step.

// File: rtl/sum8_pkg.sv
// Shared constants and width helpers for the eight-operand summer.
// Assumes unsigned operands and a fixed set size of eight lanes.
package sum8_pkg;
    localparam int NUM_OPS = 8;
    localparam int PIPE_LAT = 5;

    // Result width: eight lanes need three extra bits above the lane width.
    function automatic int sum_width(input int opw);
        return opw + 3;
    endfunction

    // Number of prefix levels needed to span a word of the given width.
    function automatic int prefix_levels(input int w);
        return $clog2(w);
    endfunction
endpackage

// File: rtl/csa42.sv
// Carry-save [4:2] compressor built from two chained 3:2 rows per bit.
// Outputs a sum and a carry vector whose total equals a+b+c+d modulo 2**W.
// Assumes the caller sized W so that the true total never exceeds 2**W-1.
module csa42 #(
    parameter int W = 9
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic [W-1:0] d,
    output logic [W-1:0] s,
    output logic [W-1:0] cy
);
    logic [W-1:0] mid;   // first-row sum per bit
    logic [W-1:0] tin;   // lateral carry between neighbouring bits

    assign tin[0] = 1'b0;
    assign cy[0]  = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // First row: three-input sum and majority.
        assign mid[i] = a[i] ^ b[i] ^ c[i];
        // Second row: fold in d and the incoming lateral carry.
        assign s[i]   = mid[i] ^ d[i] ^ tin[i];
        if (i < W - 1) begin : g_up
            assign tin[i+1] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
            assign cy[i+1]  = (mid[i] & d[i]) | (mid[i] & tin[i]) | (d[i] & tin[i]);
        end
    end
endmodule

// File: rtl/prefix_span.sv
// A contiguous run of Kogge-Stone prefix levels (purely combinational).
// Levels FIRST .. FIRST+COUNT-1 are applied; level k combines bit i with bit i-2**k.
// Assumes g_i/p_i already hold the group signals produced by levels below FIRST.
module prefix_span #(
    parameter int W     = 9,
    parameter int FIRST = 0,
    parameter int COUNT = 2
) (
    input  logic [W-1:0] g_i,
    input  logic [W-1:0] p_i,
    output logic [W-1:0] g_o,
    output logic [W-1:0] p_o
);
    // Apply each prefix level in turn to the running group generate/propagate.
    always_comb begin
        logic [W-1:0] gk, pk, gn, pn;
        gk = g_i;
        pk = p_i;
        for (int k = FIRST; k < FIRST + COUNT; k++) begin
            gn = gk;
            pn = pk;
            for (int i = 0; i < W; i++) begin
                if (i >= (1 << k)) begin
                    gn[i] = gk[i] | (pk[i] & gk[i - (1 << k)]);
                    pn[i] = pk[i] & pk[i - (1 << k)];
                end
            end
            gk = gn;
            pk = pn;
        end
        g_o = gk;
        p_o = pk;
    end
endmodule

// File: rtl/sum8_pipe.sv
// Five-stage summer of eight unsigned lanes, one set accepted per clock.
// Stage 1 compresses lanes 0-3; stages 2 and 3 fold in lanes 4-5 and 6-7,
// which wait in skew registers; stages 4 and 5 hold the two halves of a
// parallel-prefix carry-propagate adder. No stall or backpressure is supported.
module sum8_pipe
    import sum8_pkg::*;
#(
    parameter int OPW = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [NUM_OPS*OPW-1:0]     ops_in,
    output logic [sum_width(OPW)-1:0]  sum_out,
    output logic                       out_valid
);
    localparam int SW    = sum_width(OPW);
    localparam int LVL   = prefix_levels(SW);
    localparam int LV_A  = LVL / 2;
    localparam int LV_B  = LVL - LV_A;
    localparam int CSA_N = 3;

    // Zero-extend a lane to the result width.
    function automatic logic [SW-1:0] ext(input logic [OPW-1:0] v);
        return {{(SW-OPW){1'b0}}, v};
    endfunction

    logic [OPW-1:0] lane [NUM_OPS];
    for (genvar k = 0; k < NUM_OPS; k++) begin : g_lane
        assign lane[k] = ops_in[k*OPW +: OPW];
    end

    logic [OPW-1:0] dly1 [4];   // lanes 4..7 after one edge
    logic [OPW-1:0] dly2 [2];   // lanes 6..7 after two edges

    // Skew registers: keep late lanes aligned with their own set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < 4; j++) dly1[j] <= '0;
            for (int j = 0; j < 2; j++) dly2[j] <= '0;
        end else begin
            for (int j = 0; j < 4; j++) dly1[j] <= lane[4 + j];
            dly2[0] <= dly1[2];
            dly2[1] <= dly1[3];
        end
    end

    // Three compressor stages; each registers its carry-save pair.
    for (genvar g = 0; g < CSA_N; g++) begin : g_stg
        logic [SW-1:0] in_a, in_b, in_c, in_d;
        logic [SW-1:0] s_n, c_n;
        logic [SW-1:0] s_q, c_q;

        if (g == 0) begin : g_first
            assign in_a = ext(lane[0]);
            assign in_b = ext(lane[1]);
            assign in_c = ext(lane[2]);
            assign in_d = ext(lane[3]);
        end else if (g == 1) begin : g_second
            assign in_a = g_stg[0].s_q;
            assign in_b = g_stg[0].c_q;
            assign in_c = ext(dly1[0]);
            assign in_d = ext(dly1[1]);
        end else begin : g_third
            assign in_a = g_stg[1].s_q;
            assign in_b = g_stg[1].c_q;
            assign in_c = ext(dly2[0]);
            assign in_d = ext(dly2[1]);
        end

        csa42 #(.W(SW)) u_csa (
            .a  (in_a),
            .b  (in_b),
            .c  (in_c),
            .d  (in_d),
            .s  (s_n),
            .cy (c_n)
        );

        // Stage register for the carry-save pair.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s_q <= '0;
                c_q <= '0;
            end else begin
                s_q <= s_n;
                c_q <= c_n;
            end
        end
    end

    logic [SW-1:0] bit_g, bit_p, g_mid, p_mid;
    logic [SW-1:0] g4_q, p4_q, h4_q;
    logic [SW-1:0] g_fin, p_fin;

    assign bit_g = g_stg[CSA_N-1].s_q & g_stg[CSA_N-1].c_q;
    assign bit_p = g_stg[CSA_N-1].s_q ^ g_stg[CSA_N-1].c_q;

    prefix_span #(.W(SW), .FIRST(0), .COUNT(LV_A)) u_pfx_lo (
        .g_i (bit_g),
        .p_i (bit_p),
        .g_o (g_mid),
        .p_o (p_mid)
    );

    // Stage 4 register: group signals after the lower prefix levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g4_q <= '0;
            p4_q <= '0;
            h4_q <= '0;
        end else begin
            g4_q <= g_mid;
            p4_q <= p_mid;
            h4_q <= bit_p;
        end
    end

    prefix_span #(.W(SW), .FIRST(LV_A), .COUNT(LV_B)) u_pfx_hi (
        .g_i (g4_q),
        .p_i (p4_q),
        .g_o (g_fin),
        .p_o (p_fin)
    );

    logic unused_top;
    assign unused_top = ^{g_fin[SW-1], p_fin};

    // Stage 5 register: final XOR of half-sums with the incoming carries.
    always_ff @(posedge clk) begin
        if (!rst_n) sum_out <= '0;
        else        sum_out <= h4_q ^ {g_fin[SW-2:0], 1'b0};
    end

    logic [PIPE_LAT-1:0] vpipe;

    // Valid shift register, five deep, in step with the data.
    always_ff @(posedge clk) begin
        if (!rst_n) vpipe <= '0;
        else        vpipe <= {vpipe[PIPE_LAT-2:0], in_valid};
    end

    assign out_valid = vpipe[PIPE_LAT-1];
endmodule

// File: rtl/sum8_pipe_chk.sv
// Property checker for sum8_pipe, attached with bind below.
// Assumes the five-cycle latency of the block and unsigned lanes.
module sum8_pipe_chk
    import sum8_pkg::*;
#(
    parameter int OPW = 6
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [NUM_OPS*OPW-1:0]    ops_in,
    input logic [sum_width(OPW)-1:0] sum_out,
    input logic                      out_valid
);
    localparam int SW   = sum_width(OPW);
    localparam int MAXS = NUM_OPS * ((1 << OPW) - 1);

    logic [SW-1:0] total;

    // Arithmetic total of the lanes presented this cycle.
    always_comb begin
        total = '0;
        for (int k = 0; k < NUM_OPS; k++)
            total = total + SW'(ops_in[k*OPW +: OPW]);
    end

    assert_total_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> sum_out == $past(total, 5));

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##5 out_valid);

    assert_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> sum_out <= SW'(MAXS));

    assert_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##5 !out_valid);

    logic seen_rst = 1'b0;

    // After any edge with reset low, no valid output may appear.
    always_ff @(posedge clk) begin
        if (seen_rst) assert_reset_R5: assert (!out_valid);
        seen_rst <= !rst_n;
    end
endmodule

bind sum8_pipe sum8_pipe_chk #(.OPW(OPW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .ops_in    (ops_in),
    .sum_out   (sum_out),
    .out_valid (out_valid)
);

// File: tb/sum8_pipe_test.sv
`timescale 1ns/1ps
// Directed bench: each task drives one scenario; a reference pipeline
// predicts every output slot and the scenario tag names the requirement.
module sum8_pipe_test;
    localparam int OPW = 6;
    localparam int SW  = OPW + 3;
    localparam int LAT = 5;
    localparam int NL  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [NL*OPW-1:0] ops_in = '0;
    logic [SW-1:0]     sum_out;
    logic              out_valid;

    sum8_pipe #(.OPW(OPW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .ops_in    (ops_in),
        .sum_out   (sum_out),
        .out_valid (out_valid)
    );

    always #2 clk = ~clk;

    int    errors = 0;
    int    checks = 0;
    string cur_tag = "R1";

    bit            ev [LAT];
    logic [SW-1:0] es [LAT];
    string         et [LAT];

    function automatic logic [SW-1:0] ref_sum(input logic [NL*OPW-1:0] v);
        int t = 0;
        for (int k = 0; k < NL; k++) t += int'(v[k*OPW +: OPW]);
        return SW'(t);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference pipeline: capture inputs at each edge, compare shortly after.
    always @(posedge clk) begin
        for (int i = LAT - 1; i > 0; i--) begin
            ev[i] = ev[i-1];
            es[i] = es[i-1];
            et[i] = et[i-1];
        end
        ev[0] = rst_n && in_valid;
        es[0] = ref_sum(ops_in);
        et[0] = cur_tag;
        if (!rst_n)
            for (int i = 0; i < LAT; i++) ev[i] = 1'b0;
        #1;
        check(ev[LAT-1] ? "R2" : "R6", int'(out_valid), int'(ev[LAT-1]));
        if (ev[LAT-1]) check(et[LAT-1], int'(sum_out), int'(es[LAT-1]));
    end

    task automatic send(input logic [NL*OPW-1:0] v, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        ops_in   = v;
        cur_tag  = tag;
    endtask

    task automatic idle(input int n, input bit junk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            ops_in   = junk ? {$urandom, $urandom} : '0;
            cur_tag  = "R6";
        end
    endtask

    // R5: reset state and reset flush of in-flight sets.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 reset valid", int'(out_valid), 0);
        check("R5 reset sum", int'(sum_out), 0);
        rst_n = 1'b1;
        idle(3, 1'b0);
        send({NL{6'd63}}, "R5");
        send({NL{6'd21}}, "R5");
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R5 flushed", int'(out_valid), 0);
        end
    endtask

    // R7: all-zero set.
    task automatic t_zero();
        send('0, "R7");
        idle(LAT + 1, 1'b0);
    endtask

    // R8: a single full-scale lane walked over every position.
    task automatic t_walk();
        for (int k = 0; k < NL; k++) begin
            logic [NL*OPW-1:0] v = '0;
            v[k*OPW +: OPW] = '1;
            send(v, "R8");
        end
        idle(LAT + 1, 1'b0);
    endtask

    // R4: back-to-back all-maximum sets reach the top of the range.
    task automatic t_max();
        for (int i = 0; i < 6; i++) send({NL{6'd63}}, "R4");
        idle(LAT + 1, 1'b0);
    endtask

    // R3 and R1: back-to-back random sets.
    task automatic t_random();
        for (int i = 0; i < 40; i++) send({$urandom, $urandom}, "R3 R1");
        idle(LAT + 1, 1'b0);
    endtask

    // R6: alternating idle cycles carrying junk lane values.
    task automatic t_gaps();
        for (int i = 0; i < 12; i++) begin
            send({$urandom, $urandom}, "R6 R1");
            idle(1 + (i % 2), 1'b1);
        end
        idle(LAT + 1, 1'b0);
    endtask

    initial begin
        t_reset();
        t_zero();
        t_walk();
        t_max();
        t_random();
        t_gaps();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule